// File: doc/BRIEF.md
# Receive Message Mailbox with Full Flag

This block collects a fixed-length message, eight bytes by default, from a receive channel and presents it to a processor as a set of readable data registers with a full flag. Bytes arrive one per cycle under a valid strobe, and a start marker flags the first byte. Once the last byte is in, the channel later gives one verdict strobe with a good or bad result. Incoming bytes go to a staging buffer. The visible registers change only when a whole message ends with a good verdict while the mailbox is empty.

When a message is accepted, the full flag sets and a one-cycle acknowledge pulse goes toward the far end. While the flag is set, the visible registers are locked and any newly completed message is dropped. The processor learns of a message through an interrupt, which is the full flag gated by an enable input, or by polling the flag. Writing 0 to the flag releases the mailbox. Only hardware can set the flag.

A three-state machine drives collection:
- `ST_IDLE` waits for a start-marked byte.
- `ST_COLLECT` fills the staging buffer.
- `ST_AWAIT` waits for the verdict.

Its transitions are:
- IDLE→COLLECT on a start-marked byte.
- COLLECT→COLLECT on each further byte. A start marker here restarts the message at byte 0.
- COLLECT→AWAIT on the last byte.
- AWAIT→IDLE on any verdict. The verdict commits the message when it is good and the mailbox is empty, and drops it otherwise.
- AWAIT→COLLECT on a start-marked byte that arrives before any verdict.

Top module: `rx_mailbox`

## Requirements
- R1: After reset, `mbox_full`, `far_ack` and `irq` are 0 and every bit of `mbox_data` is 0.
- R2: Byte k of a message is the k-th valid byte counted from the start-marked byte, which is byte 0. It appears in `mbox_data[8k+7:8k]`. After the eighth byte, a verdict strobe with `rx_chk_ok`=1 in cycle N loads all eight bytes at once and sets `mbox_full` in cycle N+1, provided the mailbox was empty.
- R3: `far_ack` is high for exactly the one cycle in which `mbox_full` rises, and at no other time.
- R4: A verdict with `rx_chk_ok`=0 leaves `mbox_data` and `mbox_full` unchanged and produces no `far_ack`.
- R5: While `mbox_full` is 1, a newly completed good message is discarded: `mbox_data` stays unchanged and no `far_ack` is produced.
- R6: A processor write (`cpu_wr`=1) with `cpu_full_wdata`=0 clears `mbox_full` in the next cycle. The next good message then overwrites `mbox_data`.
- R7: A processor write with `cpu_full_wdata`=1 has no effect on `mbox_full`.
- R8: `irq` equals `mbox_full` AND `irq_en` in every cycle.
- R9: A start-marked byte arriving during collection restarts the message, and that byte becomes byte 0.
- R10: A verdict strobe that arrives before all eight bytes are in is ignored, and collection continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte valid strobe |
| rx_sof | input | 1 | Marks the first byte of a message (with rx_valid) |
| rx_byte | input | 8 | Received byte |
| rx_chk_valid | input | 1 | Verdict strobe for the collected message |
| rx_chk_ok | input | 1 | Verdict: 1 good, 0 bad |
| cpu_wr | input | 1 | Processor write to the full flag |
| cpu_full_wdata | input | 1 | Value written to the full flag (0 clears) |
| irq_en | input | 1 | Interrupt enable |
| mbox_data | output | 64 | Visible data registers, byte k at bits 8k+7:8k |
| mbox_full | output | 1 | Full flag |
| irq | output | 1 | Interrupt request |
| far_ack | output | 1 | One-cycle acknowledge toward the far end |

## Verification
The byte loads, the full flag and the acknowledge are all registered, so every result is due one edge after the stimulus that causes it. A verdict driven in cycle N shows `mbox_full`, `far_ack` and the new `mbox_data` in cycle N+1, and a processor clear shows on `mbox_full` one edge later. `irq` follows the flag with no extra delay. The bench drives inputs on falling edges and samples on the falling edge after the causing rising edge, so each check falls in exactly the cycle its result is due. It checks `far_ack` again one cycle later to confirm that the pulse is a single cycle.

// File: rtl/rx_mailbox_pkg.sv
package rx_mailbox_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_AWAIT   = 2'd2
    } mbox_state_t;
endpackage

// File: rtl/rx_mbox_fsm.sv
module rx_mbox_fsm
    import rx_mailbox_pkg::*;
#(
    parameter int MSG_BYTES = 8,
    localparam int CW = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic          rx_chk_valid,
    input  logic          rx_chk_ok,
    input  logic          full,
    output logic          ld,
    output logic [CW-1:0] ld_idx,
    output logic          commit
);
    localparam logic [CW-1:0] LAST = CW'(MSG_BYTES - 1);

    mbox_state_t   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Transitions and outputs
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        ld     = 1'b0;
        ld_idx = cnt_q;
        commit = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (rx_valid && rx_sof) begin
                    ld     = 1'b1;
                    ld_idx = '0;
                    cnt_d  = CW'(1);
                    st_d   = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (rx_valid) begin
                    ld = 1'b1;
                    if (rx_sof) begin
                        ld_idx = '0;
                        cnt_d  = CW'(1);
                    end else if (cnt_q == LAST) begin
                        cnt_d = '0;
                        st_d  = ST_AWAIT;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            ST_AWAIT: begin
                if (rx_chk_valid) begin
                    commit = rx_chk_ok && !full;
                    st_d   = ST_IDLE;
                end else if (rx_valid && rx_sof) begin
                    ld     = 1'b1;
                    ld_idx = '0;
                    cnt_d  = CW'(1);
                    st_d   = ST_COLLECT;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R9

    AST_NO_LOAD_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !ld); // R2
endmodule

// File: rtl/rx_mbox_stage.sv
module rx_mbox_stage #(
    parameter int MSG_BYTES = 8,
    parameter int BYTE_W    = 8,
    localparam int CW = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld,
    input  logic [CW-1:0]               ld_idx,
    input  logic [BYTE_W-1:0]           din,
    output logic [MSG_BYTES*BYTE_W-1:0] stage
);
    logic [MSG_BYTES-1:0] we;

    for (genvar i = 0; i < MSG_BYTES; i++) begin : g_byte
        assign we[i] = ld && (ld_idx == CW'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stage[i*BYTE_W +: BYTE_W] <= '0;
            else if (we[i])
                stage[i*BYTE_W +: BYTE_W] <= din;
        end
    end

    AST_ONE_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we)); // R2
endmodule

// File: rtl/rx_mbox_hold.sv
module rx_mbox_hold #(
    parameter int MSG_BYTES = 8,
    parameter int BYTE_W    = 8,
    localparam int DW = MSG_BYTES * BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [DW-1:0] stage,
    input  logic          cpu_wr,
    input  logic          cpu_wdata,
    output logic [DW-1:0] data_q,
    output logic          full_q,
    output logic          ack_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            ack_q <= commit;
            if (commit) begin
                data_q <= stage;
                full_q <= 1'b1;
            end else if (cpu_wr && !cpu_wdata) begin
                full_q <= 1'b0;
            end
        end
    end

    AST_ACK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> $rose(full_q)); // R3

    AST_RISE_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> ack_q); // R3

    AST_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |=> $stable(data_q)); // R5

    AST_W1_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_wdata && !full_q && !commit) |=> !full_q); // R7
endmodule

// File: rtl/rx_mailbox.sv
module rx_mailbox #(
    parameter int MSG_BYTES = 8,
    parameter int BYTE_W    = 8,
    localparam int DW = MSG_BYTES * BYTE_W,
    localparam int CW = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_chk_valid,
    input  logic              rx_chk_ok,
    input  logic              cpu_wr,
    input  logic              cpu_full_wdata,
    input  logic              irq_en,
    output logic [DW-1:0]     mbox_data,
    output logic              mbox_full,
    output logic              irq,
    output logic              far_ack
);
    logic          ld;
    logic [CW-1:0] ld_idx;
    logic          commit;
    logic [DW-1:0] stage;

    rx_mbox_fsm #(.MSG_BYTES(MSG_BYTES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_chk_valid (rx_chk_valid),
        .rx_chk_ok    (rx_chk_ok),
        .full         (mbox_full),
        .ld           (ld),
        .ld_idx       (ld_idx),
        .commit       (commit)
    );

    rx_mbox_stage #(.MSG_BYTES(MSG_BYTES), .BYTE_W(BYTE_W)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld),
        .ld_idx (ld_idx),
        .din    (rx_byte),
        .stage  (stage)
    );

    rx_mbox_hold #(.MSG_BYTES(MSG_BYTES), .BYTE_W(BYTE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .stage     (stage),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_full_wdata),
        .data_q    (mbox_data),
        .full_q    (mbox_full),
        .ack_q     (far_ack)
    );

    assign irq = mbox_full && irq_en;

    AST_DATA_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mbox_data) |-> $rose(mbox_full)); // R4
endmodule

// File: tb/rx_mailbox_tb.sv
module rx_mailbox_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_chk_valid = 1'b0, rx_chk_ok = 1'b0;
    logic        cpu_wr = 1'b0, cpu_full_wdata = 1'b0, irq_en = 1'b0;
    logic [63:0] mbox_data;
    logic        mbox_full, irq, far_ack;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_mailbox u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .rx_chk_valid(rx_chk_valid), .rx_chk_ok(rx_chk_ok),
        .cpu_wr(cpu_wr), .cpu_full_wdata(cpu_full_wdata), .irq_en(irq_en),
        .mbox_data(mbox_data), .mbox_full(mbox_full), .irq(irq), .far_ack(far_ack)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bytes(input logic [63:0] m, input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_byte  = m[i*8 +: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
    endtask

    // Verdict in cycle N; returns at the falling edge of cycle N+1
    task automatic verdict(input logic ok);
        rx_chk_valid = 1'b1;
        rx_chk_ok    = ok;
        @(negedge clk);
        rx_chk_valid = 1'b0;
        rx_chk_ok    = 1'b0;
    endtask

    task automatic cpu_write(input logic v);
        @(negedge clk);
        cpu_wr = 1'b1;
        cpu_full_wdata = v;
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_full_wdata = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 full", mbox_full, 0);
        check("R1 ack", far_ack, 0);
        check("R1 irq", irq, 0);
        check("R1 data", mbox_data, 0);
    endtask

    task automatic t_good(input logic [63:0] m);
        send_bytes(m, 0, 8);
        check("R2 full before verdict", mbox_full, 0);
        verdict(1'b1);
        check("R2 full set", mbox_full, 1);
        check("R3 ack with full", far_ack, 1);
        check("R2 data", mbox_data, m);
        @(negedge clk);
        check("R3 ack single cycle", far_ack, 0);
    endtask

    task automatic t_irq();
        irq_en = 1'b0;
        #1 check("R8 irq disabled", irq, 0);
        irq_en = 1'b1;
        #1 check("R8 irq enabled", irq, 1);
    endtask

    task automatic t_lock(input logic [63:0] held, input logic [63:0] m);
        send_bytes(m, 0, 8);
        verdict(1'b1);
        check("R5 no ack when full", far_ack, 0);
        check("R5 data locked", mbox_data, held);
        check("R5 still full", mbox_full, 1);
    endtask

    task automatic t_clear(input logic [63:0] held);
        cpu_write(1'b0);
        check("R6 full cleared", mbox_full, 0);
        check("R8 irq follows", irq, 0);
        check("R6 data kept", mbox_data, held);
    endtask

    task automatic t_w1();
        cpu_write(1'b1);
        check("R7 write 1 no set", mbox_full, 0);
        check("R7 no ack", far_ack, 0);
    endtask

    task automatic t_bad(input logic [63:0] held, input logic [63:0] m);
        send_bytes(m, 0, 8);
        verdict(1'b0);
        check("R4 full stays clear", mbox_full, 0);
        check("R4 no ack", far_ack, 0);
        check("R4 data unchanged", mbox_data, held);
    endtask

    task automatic t_restart(input logic [63:0] junk, input logic [63:0] m);
        send_bytes(junk, 0, 3);
        send_bytes(m, 0, 8);
        verdict(1'b1);
        check("R9 restart full", mbox_full, 1);
        check("R9 restart data", mbox_data, m);
    endtask

    task automatic t_early(input logic [63:0] held, input logic [63:0] m);
        send_bytes(m, 0, 4);
        verdict(1'b1);
        check("R10 early verdict no full", mbox_full, 0);
        check("R10 early verdict no ack", far_ack, 0);
        check("R10 data unchanged", mbox_data, held);
        send_bytes(m, 4, 4);
        verdict(1'b1);
        check("R10 completes later", mbox_full, 1);
        check("R10 data", mbox_data, m);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        localparam logic [63:0] MA = 64'h0706050403020100;
        localparam logic [63:0] MB = 64'hDEADBEEFCAFEF00D;
        localparam logic [63:0] MC = 64'h1122334455667788;
        localparam logic [63:0] MD = 64'hA5A55A5AFF0000FF;
        localparam logic [63:0] ME = 64'h0F1E2D3C4B5A6978;
        localparam logic [63:0] MF = 64'h8899AABBCCDDEEF0;
        #(CLK_PERIOD * 2);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_good(MA);
        t_irq();
        t_lock(MA, MB);
        t_clear(MA);
        t_w1();
        t_bad(MA, MC);
        t_good(MD);          // R6 overwrite after clear
        t_clear(MD);
        t_restart(MB, ME);
        t_clear(ME);
        t_early(ME, MF);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule